// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers single-cycle event strobes from an audio codec into sticky flag bits and turns them into one interrupt line. Six events are tracked: a change of headphone jack presence, a short-circuit detection, completion of a headphone ramp up or ramp down, and completion of a digital gain ramp up or ramp down. Each flag can be held off the interrupt by its own mask bit. Software reads the flag register and clears individual flags by writing ones to them.

A seventh flag-register bit is not sticky: it shows the present debounced jack level. The jack-event flag is raised inside the unit on any change of that level. Two upper bits of the mask register pick how the interrupt is signalled: active-high level, active-low level, active-high one-cycle pulse, or active-low one-cycle pulse. The analog detectors and ramp generators lie outside the unit and reach it only as strobes and a level.

Top module: `codec_evt_irq`

## Requirements
- R1: After reset the flag register reads 0 in bits 5:0, the mask register reads 0x3F (every event masked, form code 00), and `irq` is low.
- R2: A strobe on an event input sets its flag at that clock edge, and the flag holds until cleared. Bit positions: 4 short-circuit, 3 headphone ramp-up done, 2 headphone ramp-down done, 1 gain ramp-up done, 0 gain ramp-down done.
- R3: A write with `wr_sel`=0 selects the flag register. It clears each flag in bits 5:0 whose data bit is 1, and a 0 data bit leaves its flag unchanged.
- R4: When a strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Flag-register bit 6 always equals the present `jack_in` level, with no register on the path. Bit 7 always reads 0.
- R6: Any change of `jack_in` sets the jack-event flag, bit 5, at the first edge that samples the new level. A level that is steady through the end of reset raises no event.
- R7: A write with `wr_sel`=1 loads all eight bits of the mask register, and the register reads back what was written. A mask write leaves the flags unchanged.
- R8: With form code 00 (mask bits 7:6), `irq` is the OR over bits 5:0 of flag AND NOT mask, so a masked flag does not raise `irq`.
- R9: With form code 01, `irq` is the inverse of that OR, so the line is active low.
- R10: With form code 10, `irq` is high for one cycle, in the cycle after any bit of the unmasked-pending vector goes from 0 to 1, and is low at all other times.
- R11: With form code 11, `irq` is low for exactly the cycles in which form 10 would drive it high, and is high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jack_in | input | 1 | Debounced jack presence level |
| evt_short | input | 1 | Short-circuit detected strobe |
| evt_ramp_up | input | 1 | Headphone ramp-up complete strobe |
| evt_ramp_dn | input | 1 | Headphone ramp-down complete strobe |
| evt_gain_up | input | 1 | Gain ramp-up complete strobe |
| evt_gain_dn | input | 1 | Gain ramp-down complete strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flag register, 1 mask register |
| wr_data | input | 8 | Write data |
| flag_rd | output | 8 | Flag register read value |
| mask_rd | output | 8 | Mask register read value |
| irq | output | 1 | Interrupt in the selected form |

## Verification
The bench aims at the cycle where a strobe and a clearing write land on the same flag. A design that lets the clear win would lose that event. It toggles the jack level right after reset and holds it steady across reset. A design that seeds its edge detector wrongly would either miss the first change or report a change that never happened. It also checks that a pulse-form interrupt fires once per newly pending bit and does not stay asserted while the flag remains set, and that masked flags never reach a level-form output.

// File: rtl/codec_evt_pkg.sv
// Shared constants and types for the codec event interrupt unit.
// Assumes the fixed register layout: six sticky flags in bits 5:0,
// live jack level in bit 6, form code in mask bits 7:6.
package codec_evt_pkg;
    localparam int REG_W    = 8;
    localparam int EVT_N    = 6;
    localparam int JACK_BIT = 5;
    localparam int LIVE_BIT = 6;
    localparam int FORM_LSB = 6;
    localparam logic [REG_W-1:0] MASK_RST = 8'h3F;

    typedef enum logic [1:0] {
        FORM_LVL_HI = 2'b00,
        FORM_LVL_LO = 2'b01,
        FORM_PLS_HI = 2'b10,
        FORM_PLS_LO = 2'b11
    } irq_form_e;
endpackage

// File: rtl/cei_jack_watch.sv
// Jack level change detector.
// Keeps the last sampled jack level and reports a change for one cycle.
// Assumes jack_in is already debounced and synchronous to clk. During
// reset the stored level tracks the input, so no event appears at release.
module cei_jack_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic jack_in,
    output logic jack_chg
);
    logic jack_q;

    // Store the level sampled at each edge, seeded during reset.
    always_ff @(posedge clk) begin
        jack_q <= jack_in;
    end

    // A change is a difference between the present and the stored level.
    always_comb begin
        jack_chg = rst_n && (jack_in != jack_q);
    end
endmodule

// File: rtl/cei_flag_bank.sv
// Sticky event flags with write-one-to-clear.
// A set request in the same cycle as a clear takes priority.
// Assumes set and clear vectors are valid every cycle.
module cei_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_q
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_flag
            // Each flag: reset low, clear on request, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[gi] <= 1'b0;
                else if (set_vec[gi])
                    flag_q[gi] <= 1'b1;
                else if (clr_vec[gi])
                    flag_q[gi] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/cei_irq_shaper.sv
// Interrupt output former.
// Turns the vector of unmasked pending flags into a level or pulse
// output of either polarity. A pulse marks any pending bit rising 0 to 1.
// Assumes the form code is stable while a pulse is being judged.
module cei_irq_shaper
    import codec_evt_pkg::*;
#(
    parameter int N = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic [N-1:0] pend_vec,
    input  irq_form_e form,
    output logic      irq
);
    logic [N-1:0] pend_q;
    logic         any_pend;
    logic         any_new;

    // Remember last cycle's pending vector for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_vec;
    end

    // Select the output form from the level and the rise indication.
    always_comb begin
        any_pend = |pend_vec;
        any_new  = |(pend_vec & ~pend_q);
        case (form)
            FORM_LVL_HI: irq = any_pend;
            FORM_LVL_LO: irq = ~any_pend;
            FORM_PLS_HI: irq = any_new;
            default:     irq = ~any_new;
        endcase
    end
endmodule

// File: rtl/codec_evt_irq.sv
// Codec interrupt flag and mask unit, top level.
// Collects event strobes into sticky flags, applies per-event masks and
// drives one interrupt in a programmable form. Flag bit 6 is the live jack
// level. Assumes all inputs are synchronous to clk and strobes last one cycle.
module codec_evt_irq
    import codec_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jack_in,
    input  logic             evt_short,
    input  logic             evt_ramp_up,
    input  logic             evt_ramp_dn,
    input  logic             evt_gain_up,
    input  logic             evt_gain_dn,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] flag_rd,
    output logic [REG_W-1:0] mask_rd,
    output logic             irq
);
    logic             jack_chg;
    logic [EVT_N-1:0] set_vec;
    logic [EVT_N-1:0] clr_vec;
    logic [EVT_N-1:0] flag_q;
    logic [REG_W-1:0] mask_q;
    logic [EVT_N-1:0] pend_vec;
    irq_form_e        form;

    cei_jack_watch u_jack (
        .clk      (clk),
        .rst_n    (rst_n),
        .jack_in  (jack_in),
        .jack_chg (jack_chg)
    );

    // Gather set requests and clear requests into flag-aligned vectors.
    always_comb begin
        set_vec = {jack_chg, evt_short, evt_ramp_up, evt_ramp_dn,
                   evt_gain_up, evt_gain_dn};
        clr_vec = (wr_en && !wr_sel) ? wr_data[EVT_N-1:0] : '0;
    end

    cei_flag_bank #(.N(EVT_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (flag_q)
    );

    // Mask register: full-width load on a mask-targeted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RST;
        else if (wr_en && wr_sel)
            mask_q <= wr_data;
    end

    // Derive the pending vector, the form code and the read views.
    always_comb begin
        pend_vec = flag_q & ~mask_q[EVT_N-1:0];
        form     = irq_form_e'(mask_q[FORM_LSB+1:FORM_LSB]);
        flag_rd  = '0;
        flag_rd[EVT_N-1:0] = flag_q;
        flag_rd[LIVE_BIT]  = jack_in;
        mask_rd  = mask_q;
    end

    cei_irq_shaper #(.N(EVT_N)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vec (pend_vec),
        .form     (form),
        .irq      (irq)
    );
endmodule

// File: rtl/codec_evt_irq_chk.sv
// Property checker for the codec interrupt unit, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module codec_evt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       jack_in,
    input logic       evt_short,
    input logic       evt_ramp_up,
    input logic       evt_gain_up,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] flag_rd,
    input logic [7:0] mask_rd,
    input logic       irq
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_rd == 8'h3F && flag_rd[5:0] == 6'd0 && !irq));

    a_r2_short_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_short |=> flag_rd[4]);

    a_r3_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[3] && !evt_ramp_up) |=> !flag_rd[3]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_gain_up && wr_en && !wr_sel && wr_data[1]) |=> flag_rd[1]);

    a_r5_live_jack: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd[6] == jack_in) && !flag_rd[7]);

    a_r6_jack_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(jack_in) |=> flag_rd[5]);

    a_r8_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd[7:6] == 2'b00) |-> (irq == |(flag_rd[5:0] & ~mask_rd[5:0])));
endmodule

bind codec_evt_irq codec_evt_irq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .jack_in     (jack_in),
    .evt_short   (evt_short),
    .evt_ramp_up (evt_ramp_up),
    .evt_gain_up (evt_gain_up),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .flag_rd     (flag_rd),
    .mask_rd     (mask_rd),
    .irq         (irq)
);

// File: tb/codec_evt_irq_tb_top.sv
`timescale 1ns/1ps
module codec_evt_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       jack_in = 1'b0;
    logic [4:0] ev = 5'd0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] flag_rd, mask_rd;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // bench model state
    logic [5:0] mflag;
    logic [7:0] mmask;
    logic [5:0] mpq;
    logic       mjq;

    always #2 clk = ~clk;

    codec_evt_irq dut_i (
        .clk(clk), .rst_n(rst_n), .jack_in(jack_in),
        .evt_short(ev[4]), .evt_ramp_up(ev[3]), .evt_ramp_dn(ev[2]),
        .evt_gain_up(ev[1]), .evt_gain_dn(ev[0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_rd(flag_rd), .mask_rd(mask_rd), .irq(irq)
    );

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic [5:0] p;
        logic lvl, nw;
        p   = mflag & ~mmask[5:0];
        lvl = |p;
        nw  = |(p & ~mpq);
        case (mmask[7:6])
            2'b00:   return lvl;
            2'b01:   return ~lvl;
            2'b10:   return nw;
            default: return ~nw;
        endcase
    endfunction

    function automatic string irq_tag();
        case (mmask[7:6])
            2'b00:   return "R8 irq level high";
            2'b01:   return "R9 irq level low";
            2'b10:   return "R10 irq pulse high";
            default: return "R11 irq pulse low";
        endcase
    endfunction

    // One clock: drive at negedge, update model at posedge, compare after.
    task automatic step(input logic [4:0] e, input logic j, input logic we,
                        input logic sel, input logic [7:0] d);
        logic [5:0] clr;
        @(negedge clk);
        ev = e; jack_in = j; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        clr   = (we && !sel) ? d[5:0] : 6'd0;
        mpq   = mflag & ~mmask[5:0];
        mflag = (mflag & ~clr) | {j != mjq, e};
        mjq   = j;
        if (we && sel) mmask = d;
        #1;
        chk("R2 flag bits", {2'b00, flag_rd[5:0]}, {2'b00, mflag});
        chk("R5 live jack", {6'd0, flag_rd[7:6]}, {7'd0, j});
        chk("R7 mask readback", mask_rd, mmask);
        chk(irq_tag(), {7'd0, irq}, {7'd0, exp_irq()});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        jack_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mflag = 6'd0; mmask = 8'h3F; mpq = 6'd0; mjq = 1'b1;
        // R1: reset state
        chk("R1 flags after reset", flag_rd, 8'h40);
        chk("R1 mask after reset", mask_rd, 8'h3F);
        chk("R1 irq after reset", {7'd0, irq}, 8'd0);

        // R6: steady jack through reset gives no event
        step(5'd0, 1'b1, 1'b0, 1'b0, 8'd0);
        chk("R6 no event at release", {7'd0, flag_rd[5]}, 8'd0);

        // R8 masking: event while masked raises flag but not irq
        step(5'b00001, 1'b1, 1'b0, 1'b0, 8'd0);
        chk("R8 masked flag no irq", {7'd0, irq}, 8'd0);
        chk("R2 gain-down flag", {7'd0, flag_rd[0]}, 8'd1);

        // R7: unmask all, form 00; flags untouched
        step(5'd0, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R7 mask write", mask_rd, 8'h00);
        chk("R7 flags kept", {7'd0, flag_rd[0]}, 8'd1);
        chk("R8 unmasked level", {7'd0, irq}, 8'd1);

        // R2/R3: short event, clear by ones, zeros ignored
        step(5'b10000, 1'b1, 1'b0, 1'b0, 8'd0);
        chk("R2 short flag", {7'd0, flag_rd[4]}, 8'd1);
        step(5'd0, 1'b1, 1'b1, 1'b0, 8'h00);
        chk("R3 zero write keeps", {2'd0, flag_rd[5:0]}, 8'h11);
        step(5'd0, 1'b1, 1'b1, 1'b0, 8'h10);
        chk("R3 clear short", {2'd0, flag_rd[5:0]}, 8'h01);

        // R4: set and clear same cycle
        step(5'b00010, 1'b1, 1'b1, 1'b0, 8'h03);
        chk("R4 set wins", {2'd0, flag_rd[5:0]}, 8'h02);

        // R6/R5: jack change
        step(5'd0, 1'b0, 1'b1, 1'b0, 8'h3F);
        chk("R6 jack event", {2'd0, flag_rd[5:0]}, 8'h20);
        chk("R5 live low", {7'd0, flag_rd[6]}, 8'd0);
        step(5'd0, 1'b0, 1'b1, 1'b0, 8'h20);
        chk("R8 all clear", {7'd0, irq}, 8'd0);

        // R9: form 01
        step(5'd0, 1'b0, 1'b1, 1'b1, 8'h40);
        chk("R9 idle high", {7'd0, irq}, 8'd1);
        step(5'b01000, 1'b0, 1'b0, 1'b0, 8'd0);
        chk("R9 pending low", {7'd0, irq}, 8'd0);
        step(5'd0, 1'b0, 1'b1, 1'b0, 8'h3F);

        // R10: form 10, single pulse
        step(5'd0, 1'b0, 1'b1, 1'b1, 8'h80);
        step(5'b00100, 1'b0, 1'b0, 1'b0, 8'd0);
        chk("R10 pulse high", {7'd0, irq}, 8'd1);
        step(5'd0, 1'b0, 1'b0, 1'b0, 8'd0);
        chk("R10 pulse one cycle", {7'd0, irq}, 8'd0);
        step(5'd0, 1'b0, 1'b1, 1'b0, 8'h3F);

        // R11: form 11
        step(5'd0, 1'b0, 1'b1, 1'b1, 8'hC0);
        chk("R11 idle high", {7'd0, irq}, 8'd1);
        step(5'b00001, 1'b0, 1'b0, 1'b0, 8'd0);
        chk("R11 pulse low", {7'd0, irq}, 8'd0);
        step(5'd0, 1'b0, 1'b0, 1'b0, 8'd0);
        chk("R11 pulse ends", {7'd0, irq}, 8'd1);

        // Random phase against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] e;
            logic j, we, sel;
            logic [7:0] d;
            e = 5'd0;
            for (int b = 0; b < 5; b++) e[b] = ($urandom_range(0, 9) == 0);
            j   = ($urandom_range(0, 15) == 0) ? ~jack_in : jack_in;
            we  = ($urandom_range(0, 3) == 0);
            sel = ($urandom_range(0, 3) == 0);
            d   = 8'($urandom);
            step(e, j, we, sel, d);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule